// File: doc/BRIEF.md
# Translation Fault Interrupt Unit

This block sits beside an address translation unit and turns its fault events into a single level interrupt for the processor. Every cycle the translation unit may present a fault event. The event carries a vector of eight fault kinds, the virtual address that failed, the physical address involved, and the requester's group and port numbers. The unit keeps a sticky status bit for each kind. It latches the details of the first fault only, and holds them until software clears the interrupt. The interrupt output is high while any status bit is set whose enable bit is also set.

Software reaches the unit through a simple word-indexed register port. Writes take effect at a clock edge and reads are combinational. The control register holds the per-kind enables and a self-clearing clear bit. Software sets the clear bit with a read-modify-write, so the enables it writes back are kept. A separate mode register holds a two-bit protect-select field and a coherent-enable flag, and both drive outputs toward the translation unit. Read-only registers return the status, the page-aligned fault virtual address, the fault physical address, and a packed requester ID. Software decodes that ID into a group and a port. The fault record does not say whether the failing access was a read or a write.

Register indices on `reg_addr`: 0 control, 1 mode, 2 status, 3 fault virtual address, 4 fault physical address, 5 requester ID. Indices 6 and 7 read as zero.

Top module: `xlat_fault_irq`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `prot_sel` is 0 and `coherent_en` is 0.
- R2: Control register (index 0) bits 7:0 are the kind enables and read back as written. Bit 12 is the clear bit and always reads 0. All other bits read 0.
- R3: When `flt_valid` is high, each set bit i of `flt_kind` sets status bit i (index 2). Bit 0 is translation, 1 multi-hit, 2 invalid physical address, 3 entry replacement, 4 table walk, 5 TLB miss, 6 prefetch FIFO overflow, 7 miss FIFO overflow. Status bits stay set until a clear, and an enable bit has no effect on its status bit.
- R4: `irq` is high exactly when some status bit and its matching enable bit are both 1.
- R5: A control write with bit 12 set clears all status bits and the fault record from the next cycle on. The enable bits in the same write are taken.
- R6: The fault virtual address register (index 3) returns the event's virtual address with bits 11:0 zeroed. The fault physical address register (index 4) returns the physical address unchanged.
- R7: The requester ID register (index 5) holds (6 minus group) in bits 15:13 and the port in bits 11:8. All other bits are 0.
- R8: Only the first fault after reset or after a clear is recorded. Later faults OR into the status but leave registers 3, 4 and 5 unchanged.
- R9: A fault in the same cycle as a clear write becomes the new first fault. The status then equals that fault's kinds only.
- R10: Mode register (index 1) bits 6:5 are the protect select, driven on `prot_sel`. Bit 8 is the coherent enable, driven on `coherent_en`. Other bits read 0.
- R11: Writes to indices 2 through 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault event present this cycle |
| flt_kind | input | 8 | Fault kinds of the event, one bit per kind |
| flt_va | input | 32 | Faulting virtual address |
| flt_pa | input | 32 | Physical address of the fault |
| flt_group | input | 3 | Requester group number |
| flt_port | input | 4 | Requester port number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Level interrupt to the processor |
| prot_sel | output | 2 | Protect select to the translation unit |
| coherent_en | output | 1 | Coherent enable to the translation unit |

## Verification
A fault event or register write sampled at one rising edge shows up in the registers, in `irq` and on the mode outputs right after that edge. There is exactly one cycle of latency and no further pipeline stage. The bench drives every input on a falling edge and holds it across one rising edge. It takes the register readback and `irq` at the next falling edge, after `reg_addr` has settled, because reads are combinational. For the same-cycle clear case, the fault and the clear write share one rising edge, and the status and record are checked at the falling edge that follows.

// File: rtl/xfi_pkg.sv
package xfi_pkg;
  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_MODE = 3'd1,
    RA_STAT = 3'd2,
    RA_FVA  = 3'd3,
    RA_FPA  = 3'd4,
    RA_RID  = 3'd5
  } reg_idx_e;

  localparam int CLR_BIT   = 12;
  localparam int PROT_LSB  = 5;
  localparam int PROT_W    = 2;
  localparam int COH_BIT   = 8;
  localparam int GRP_LSB   = 13;
  localparam int PORT_LSB  = 8;
  localparam int GRP_BIAS  = 6;
endpackage

// File: rtl/xfi_cfg_regs.sv
module xfi_cfg_regs
  import xfi_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [N_SRC-1:0]     en,
  output logic                 clr,
  output logic [PROT_W-1:0]    prot_sel,
  output logic                 coh
);
  logic                ctrl_we, mode_we;
  logic [N_SRC-1:0]    en_q, en_d;
  logic [PROT_W-1:0]   prot_q, prot_d;
  logic                coh_q, coh_d;

  always_comb begin
    ctrl_we = we && (addr == RA_CTRL);
    mode_we = we && (addr == RA_MODE);
    en_d    = wdata[N_SRC-1:0];
    prot_d  = wdata[PROT_LSB +: PROT_W];
    coh_d   = wdata[COH_BIT];
    clr     = ctrl_we && wdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ctrl_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      coh_q  <= 1'b0;
    end else if (mode_we) begin
      prot_q <= prot_d;
      coh_q  <= coh_d;
    end
  end

  assign en       = en_q;
  assign prot_sel = prot_q;
  assign coh      = coh_q;

  // R10: mode fields only move on a mode write
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> ($stable(prot_sel) && $stable(coh)));
  // R2: enables only move on a control write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(en));
endmodule

// File: rtl/xfi_fault_latch.sv
module xfi_fault_latch
  import xfi_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int GRP_W      = 3,
  parameter int PORT_W     = 4,
  parameter int ID_W       = GRP_LSB + GRP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [N_SRC-1:0]   kind,
  input  logic [VA_W-1:0]    va,
  input  logic [PA_W-1:0]    pa,
  input  logic [GRP_W-1:0]   group,
  input  logic [PORT_W-1:0]  port,
  input  logic               clr,
  output logic [N_SRC-1:0]   status,
  output logic [VA_W-1:0]    va_q,
  output logic [PA_W-1:0]    pa_q,
  output logic [ID_W-1:0]    id_q
);
  localparam logic [VA_W-1:0]  PAGE_MASK =
    ~(({{(VA_W-1){1'b0}}, 1'b1} << PAGE_SHIFT) - {{(VA_W-1){1'b0}}, 1'b1});
  localparam logic [GRP_W-1:0] BIAS = GRP_W'(GRP_BIAS);

  logic [N_SRC-1:0] stat_q, stat_d;
  logic             held_q, held_d;
  logic             cap;
  logic [VA_W-1:0]  va_d;
  logic [PA_W-1:0]  pa_d;
  logic [ID_W-1:0]  id_d;
  logic [VA_W-1:0]  va_r;
  logic [PA_W-1:0]  pa_r;
  logic [ID_W-1:0]  id_r;

  always_comb begin
    stat_d = (clr ? '0 : stat_q) | (valid ? kind : '0);
    held_d = (clr ? 1'b0 : held_q) | valid;
    cap    = valid && (clr || !held_q);
    va_d   = va & PAGE_MASK;
    pa_d   = pa;
    id_d   = '0;
    id_d[GRP_LSB +: GRP_W]   = BIAS - group;
    id_d[PORT_LSB +: PORT_W] = port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      held_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_r <= '0;
      pa_r <= '0;
      id_r <= '0;
    end else if (cap) begin
      va_r <= va_d;
      pa_r <= pa_d;
      id_r <= id_d;
    end else if (clr) begin
      va_r <= '0;
      pa_r <= '0;
      id_r <= '0;
    end
  end

  assign status = stat_q;
  assign va_q   = va_r;
  assign pa_q   = pa_r;
  assign id_q   = id_r;

  // R3: status bits are sticky without a clear
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));
  // R5: a clear with no new fault empties the status
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !valid) |=> (status == '0));
  // R8: the record holds while a fault is held and no clear arrives
  p_first_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr) |=> ($stable(va_q) && $stable(pa_q) && $stable(id_q)));
  // R9: a fault together with a clear leaves exactly its kinds
  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && valid) |=> (status == $past(kind)));
endmodule

// File: rtl/xlat_fault_irq.sv
module xlat_fault_irq
  import xfi_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int DATA_W     = 32,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int GRP_W      = 3,
  parameter int PORT_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [N_SRC-1:0]   flt_kind,
  input  logic [VA_W-1:0]    flt_va,
  input  logic [PA_W-1:0]    flt_pa,
  input  logic [GRP_W-1:0]   flt_group,
  input  logic [PORT_W-1:0]  flt_port,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic [1:0]         prot_sel,
  output logic               coherent_en
);
  localparam int ID_W = GRP_LSB + GRP_W;

  logic [N_SRC-1:0] en, status;
  logic             clr;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  pa_q;
  logic [ID_W-1:0]  id_q;
  logic [DATA_W-1:0] mode_rd;

  xfi_cfg_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .en(en), .clr(clr), .prot_sel(prot_sel),
    .coh(coherent_en)
  );

  xfi_fault_latch #(
    .N_SRC(N_SRC), .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .GRP_W(GRP_W), .PORT_W(PORT_W), .ID_W(ID_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .valid(flt_valid), .kind(flt_kind),
    .va(flt_va), .pa(flt_pa), .group(flt_group), .port(flt_port),
    .clr(clr), .status(status), .va_q(va_q), .pa_q(pa_q), .id_q(id_q)
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[PROT_LSB +: PROT_W] = prot_sel;
    mode_rd[COH_BIT]            = coherent_en;
    case (reg_addr)
      RA_CTRL: reg_rdata = DATA_W'(en);
      RA_MODE: reg_rdata = mode_rd;
      RA_STAT: reg_rdata = DATA_W'(status);
      RA_FVA:  reg_rdata = DATA_W'(va_q);
      RA_FPA:  reg_rdata = DATA_W'(pa_q);
      RA_RID:  reg_rdata = DATA_W'(id_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(status & en);

  // R4: a raised interrupt always has a pending enabled source
  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status != '0) && (en != '0)));
  // R5: after a clear with no fault the interrupt is low
  p_irq_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !flt_valid) |=> !irq);
endmodule

// File: tb/tb_xlat_fault_irq.sv
module tb_xlat_fault_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [7:0]  flt_kind = '0;
  logic [31:0] flt_va = '0;
  logic [31:0] flt_pa = '0;
  logic [2:0]  flt_group = '0;
  logic [3:0]  flt_port = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [1:0]  prot_sel;
  logic        coherent_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  xlat_fault_irq dut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_kind(flt_kind),
    .flt_va(flt_va), .flt_pa(flt_pa), .flt_group(flt_group),
    .flt_port(flt_port), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .prot_sel(prot_sel), .coherent_en(coherent_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fault(input logic [7:0] k, input logic [31:0] va,
                       input logic [31:0] pa, input logic [2:0] g,
                       input logic [3:0] p);
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = k; flt_va = va; flt_pa = pa;
    flt_group = g; flt_port = p;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic clear_irq();
    logic [31:0] c;
    rd(3'd0, c);
    wr(3'd0, c | 32'h1000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 mode outs after reset", {29'b0, coherent_en, prot_sel}, 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d);
    check("R2 enables, clear bit reads 0", d, 32'h0000_00FF);
    wr(3'd0, 32'h0000_00A5);
    rd(3'd0, d);
    check("R2 enable readback", d, 32'h0000_00A5);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_status_irq();
    logic [31:0] d;
    clear_irq();
    fault(8'h20, 32'h1000_0FFF, 32'h2000_0000, 3'd1, 4'd3);
    rd(3'd2, d);
    check("R3 TLB miss sets status bit 5", d, 32'h20);
    check("R4 irq low with source disabled", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0000_0001);
    check("R4 irq low, other source enabled", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0000_0020);
    check("R4 irq high when enabled", {31'b0, irq}, 32'h1);
    fault(8'h81, 32'h0, 32'h0, 3'd0, 4'd0);
    rd(3'd2, d);
    check("R3 status sticky and OR", d, 32'hA1);
    wr(3'd0, 32'h0000_0000);
    check("R4 irq low after disable", {31'b0, irq}, 32'h0);
    rd(3'd2, d);
    check("R3 status kept when enable dropped", d, 32'hA1);
    wr(3'd0, 32'h0000_0040);
    check("R4 irq low, bit 6 not pending", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(3'd0, 32'h0000_0022);
    fault(8'h02, 32'h0, 32'h0, 3'd0, 4'd0);
    check("R4 irq before clear", {31'b0, irq}, 32'h1);
    clear_irq();
    rd(3'd2, d);
    check("R5 status cleared", d, 32'h0);
    check("R5 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd0, d);
    check("R5 enables preserved by RMW clear", d, 32'h22);
    rd(3'd3, d);
    check("R5 record cleared", d, 32'h0);
  endtask

  task automatic t_record();
    logic [31:0] d;
    clear_irq();
    fault(8'h01, 32'h1234_5ABC, 32'h8765_4321, 3'd2, 4'd9);
    rd(3'd3, d);
    check("R6 fault VA low bits zero", d, 32'h1234_5000);
    rd(3'd4, d);
    check("R6 fault PA", d, 32'h8765_4321);
    rd(3'd5, d);
    check("R7 requester id group 2 port 9", d, 32'h0000_8900);
    fault(8'h10, 32'hFFFF_FFFF, 32'h1111_1111, 3'd5, 4'd1);
    rd(3'd3, d);
    check("R8 VA kept on second fault", d, 32'h1234_5000);
    rd(3'd4, d);
    check("R8 PA kept on second fault", d, 32'h8765_4321);
    rd(3'd5, d);
    check("R8 id kept on second fault", d, 32'h0000_8900);
    rd(3'd2, d);
    check("R8 second fault still in status", d, 32'h11);
    clear_irq();
    fault(8'h08, 32'hABCD_EFFF, 32'h0000_0080, 3'd0, 4'd15);
    rd(3'd5, d);
    check("R7 requester id group 0 port 15", d, 32'h0000_CF00);
    rd(3'd3, d);
    check("R8 new first fault after clear", d, 32'hABCD_E000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_1004;
    flt_valid = 1'b1; flt_kind = 8'h04; flt_va = 32'h5555_5123;
    flt_pa = 32'h0C0C_0C0C; flt_group = 3'd6; flt_port = 4'd2;
    @(negedge clk);
    reg_we = 1'b0; flt_valid = 1'b0;
    rd(3'd2, d);
    check("R9 status holds only the new kinds", d, 32'h04);
    rd(3'd3, d);
    check("R9 new fault recorded", d, 32'h5555_5000);
    rd(3'd5, d);
    check("R9 id of new fault", d, 32'h0000_0200);
    check("R9 irq from new fault", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d);
    check("R10 mode readback", d, 32'h0000_0160);
    check("R10 mode outputs", {29'b0, coherent_en, prot_sel}, 32'h7);
    wr(3'd1, 32'h0000_0040);
    rd(3'd1, d);
    check("R10 protect select 2", d, 32'h0000_0040);
    check("R10 outputs select 2", {29'b0, coherent_en, prot_sel}, 32'h2);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    for (int a = 2; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    rd(3'd2, d);
    check("R11 status unchanged by write", d, 32'h04);
    rd(3'd3, d);
    check("R11 VA unchanged by write", d, 32'h5555_5000);
    rd(3'd4, d);
    check("R11 PA unchanged by write", d, 32'h0C0C_0C0C);
    rd(3'd5, d);
    check("R11 id unchanged by write", d, 32'h0000_0200);
    rd(3'd0, d);
    check("R11 control unchanged", d, 32'h04);
    rd(3'd1, d);
    check("R11 mode unchanged", d, 32'h40);
    rd(3'd6, d);
    check("R11 unused index reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_status_irq();
    t_clear();
    t_record();
    t_same_cycle();
    t_mode();
    t_readonly();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule